// File: doc/BRIEF.md
# Sub-Field Drive Timing Sequencer

This block produces the digital control sequence for one frame of a display that builds gray levels from time-weighted sub-fields. A frame is cut into one pass per bit of the 8-bit pixel value, starting with the most significant bit. Every pass runs the same three steps in a fixed order. First an erase/prime window is opened. Then every line is scanned in turn while one bit plane of that line is driven onto the column outputs. Finally a burst of alternating X and Y sustain strobes follows, and its length is proportional to the weight of that bit.

The pixel store sits outside the block. The sequencer presents the line it is scanning on `line_sel` and expects all columns of that line on `rd_pixels` in the same cycle, as a combinational read. The base sustain count, the erase window length, the scan pulse length and the inter-line gap are all run-time inputs. A pulse on `frame_start` launches a frame. `frame_done` marks the return to idle.

Top module: `sfd_sequencer`

## Requirements
- R1: After reset, and with no `frame_start`, the outputs `reset_en`, `scan_pulse`, `addr_data`, `sus_x`, `sus_y` and `frame_done` are all low.
- R2: A `frame_start` seen in idle begins eight sub-fields, indexed k = 0..7. Each one runs an erase window, then addressing, then sustain. The erase window holds `reset_en` high for exactly `reset_len` cycles, and a value of 0 is taken as 1.
- R3: During addressing, `line_sel` steps through lines 0 to LINES-1 in ascending order. `scan_pulse` stays high for exactly `scan_len` cycles per line (0 taken as 1). Between two lines it stays low for exactly `gap_len` cycles (0 taken as 1).
- R4: While `scan_pulse` is high, `addr_data[c]` equals bit (7-k) of the pixel of column c on line `line_sel`. That pixel sits at `rd_pixels[8c+7:8c]`. `addr_data` is zero outside the scan pulses.
- R5: In sub-field k the sustain burst holds exactly (128 >> k) * `base_t` strobes, with X and Y strobes counted together.
- R6: Sustain strobes alternate, starting with X in every sub-field. Each strobe lasts one cycle and is followed by at least one cycle with both strobes low. `sus_x` and `sus_y` are never high together.
- R7: After the sustain burst of the last sub-field, `frame_done` pulses high for exactly one cycle and the block returns to idle.
- R8: A `frame_start` that arrives while a frame is running is ignored. The frame runs to completion with exactly eight sub-fields and one `frame_done`, and no second frame follows.
- R9: Over one frame, the sustain strobes that occur in sub-fields where a cell's address bit was set add up to the cell's gray value times `base_t`.
- R10: With `base_t` = 0 the frame still runs all eight sub-fields and signals `frame_done`, but no sustain strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Launches one frame when idle |
| base_t | input | CNT_W | Base sustain count per unit weight |
| reset_len | input | CNT_W | Erase window length in cycles |
| scan_len | input | CNT_W | Scan pulse length in cycles |
| gap_len | input | CNT_W | Low cycles between two scan pulses |
| rd_pixels | input | COLS*8 | All pixels of line `line_sel`, column c at bits 8c+7:8c |
| reset_en | output | 1 | Erase/prime window active |
| scan_pulse | output | 1 | Scan pulse on the selected line |
| line_sel | output | LINE_W | Line being scanned, also the pixel store read address |
| addr_data | output | COLS | Column address data for the current bit plane |
| sus_x | output | 1 | X sustain strobe |
| sus_y | output | 1 | Y sustain strobe |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that the four configuration inputs stay constant while a frame runs. They also assume that `rd_pixels` is a pure function of `line_sel`, so that the bit plane seen during a scan pulse cannot change under it. The bench writes the configuration and the pixel array only while the block is idle, at a falling edge. It models the pixel store as a combinational lookup indexed by `line_sel`. Strobes on `frame_start` are driven at a falling edge, including the one aimed at the middle of a frame.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ERASE,
        PH_SCAN,
        PH_GAP,
        PH_SUSTAIN
    } phase_e;
endpackage

// File: rtl/sfd_plane_select.sv
module sfd_plane_select #(
    parameter int COLS  = 4,
    parameter int PIX_W = 8,
    localparam int SF_W = $clog2(PIX_W)
) (
    input  logic                  en,
    input  logic [SF_W-1:0]       plane,
    input  logic [COLS*PIX_W-1:0] pixels,
    output logic [COLS-1:0]       bits
);
    localparam logic [SF_W-1:0] TOP_BIT = SF_W'(PIX_W - 1);

    // Sub-field index 0 carries the most significant bit.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [PIX_W-1:0] pix;
        assign pix     = pixels[c*PIX_W +: PIX_W];
        assign bits[c] = en & pix[TOP_BIT - plane];
    end
endmodule

// File: rtl/sfd_sustain_pulser.sv
module sfd_sustain_pulser #(
    parameter int TOT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TOT_W-1:0] total,
    output logic             sus_x,
    output logic             sus_y,
    output logic             burst_done
);
    typedef struct packed {
        logic             active;
        logic             ph;
        logic [TOT_W-1:0] cnt;
        logic [TOT_W-1:0] total;
        logic             done;
    } pul_s;

    pul_s pul_d, pul_q;

    always_comb begin
        pul_d      = pul_q;
        pul_d.done = 1'b0;
        if (start) begin
            pul_d.active = 1'b1;
            pul_d.ph     = 1'b0;
            pul_d.cnt    = '0;
            pul_d.total  = total;
        end else if (pul_q.active) begin
            if (pul_q.total == '0) begin
                pul_d.active = 1'b0;
                pul_d.done   = 1'b1;
            end else if (!pul_q.ph) begin
                pul_d.ph = 1'b1;
            end else begin
                pul_d.ph = 1'b0;
                if (pul_q.cnt == pul_q.total - 1'b1) begin
                    pul_d.active = 1'b0;
                    pul_d.done   = 1'b1;
                end else begin
                    pul_d.cnt = pul_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pul_q <= '0;
        else        pul_q <= pul_d;
    end

    logic strobe;
    assign strobe     = pul_q.active & ~pul_q.ph & (pul_q.total != '0);
    assign sus_x      = strobe & ~pul_q.cnt[0];
    assign sus_y      = strobe &  pul_q.cnt[0];
    assign burst_done = pul_q.done;

    // Tracks which polarity fired last within a burst.
    logic last_x_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     last_x_q <= 1'b0;
        else if (start) last_x_q <= 1'b0;
        else if (sus_x) last_x_q <= 1'b1;
        else if (sus_y) last_x_q <= 1'b0;
    end

    a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(sus_x && sus_y));
    a_r6_low_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sus_x || sus_y) |=> !(sus_x || sus_y));
    a_r6_x_after_y: assert property (@(posedge clk) disable iff (!rst_n)
        sus_x |-> !last_x_q);
    a_r6_y_after_x: assert property (@(posedge clk) disable iff (!rst_n)
        sus_y |-> last_x_q);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);
endmodule

// File: rtl/sfd_phase_fsm.sv
module sfd_phase_fsm
    import sfd_pkg::*;
#(
    parameter int LINES = 480,
    parameter int PIX_W = 8,
    parameter int CNT_W = 16,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SF_W   = $clog2(PIX_W),
    localparam int TOT_W  = CNT_W + PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [CNT_W-1:0]  base_t,
    input  logic [CNT_W-1:0]  reset_len,
    input  logic [CNT_W-1:0]  scan_len,
    input  logic [CNT_W-1:0]  gap_len,
    input  logic              sus_done,
    output logic              reset_en,
    output logic              scan_pulse,
    output logic [LINE_W-1:0] line_sel,
    output logic [SF_W-1:0]   plane,
    output logic              sus_start,
    output logic [TOT_W-1:0]  sus_total,
    output logic              frame_done
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
    localparam logic [SF_W-1:0]   LAST_SF   = SF_W'(PIX_W - 1);

    typedef struct packed {
        phase_e            state;
        logic [SF_W-1:0]   sf;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  cnt;
        logic              start;
        logic              done;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    logic [CNT_W-1:0] erase_lim, scan_lim, gap_lim;
    assign erase_lim = (reset_len == '0) ? '0 : reset_len - 1'b1;
    assign scan_lim  = (scan_len  == '0) ? '0 : scan_len  - 1'b1;
    assign gap_lim   = (gap_len   == '0) ? '0 : gap_len   - 1'b1;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.start = 1'b0;
        fsm_d.done  = 1'b0;
        unique case (fsm_q.state)
            PH_IDLE: begin
                if (frame_start) begin
                    fsm_d.state = PH_ERASE;
                    fsm_d.sf    = '0;
                    fsm_d.cnt   = '0;
                end
            end
            PH_ERASE: begin
                if (fsm_q.cnt == erase_lim) begin
                    fsm_d.state = PH_SCAN;
                    fsm_d.cnt   = '0;
                    fsm_d.line  = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            PH_SCAN: begin
                if (fsm_q.cnt == scan_lim) begin
                    fsm_d.state = PH_GAP;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (fsm_q.cnt == gap_lim) begin
                    fsm_d.cnt = '0;
                    if (fsm_q.line == LAST_LINE) begin
                        fsm_d.state = PH_SUSTAIN;
                        fsm_d.start = 1'b1;
                    end else begin
                        fsm_d.state = PH_SCAN;
                        fsm_d.line  = fsm_q.line + 1'b1;
                    end
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            PH_SUSTAIN: begin
                if (sus_done) begin
                    if (fsm_q.sf == LAST_SF) begin
                        fsm_d.state = PH_IDLE;
                        fsm_d.done  = 1'b1;
                    end else begin
                        fsm_d.state = PH_ERASE;
                        fsm_d.sf    = fsm_q.sf + 1'b1;
                        fsm_d.cnt   = '0;
                    end
                end
            end
            default: fsm_d.state = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= PH_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign reset_en   = (fsm_q.state == PH_ERASE);
    assign scan_pulse = (fsm_q.state == PH_SCAN);
    assign line_sel   = fsm_q.line;
    assign plane      = fsm_q.sf;
    assign sus_start  = fsm_q.start;
    assign frame_done = fsm_q.done;
    assign sus_total  = TOT_W'(base_t) << (LAST_SF - fsm_q.sf);

    a_r3_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        scan_pulse |-> (line_sel <= LAST_LINE));
    a_r2_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_en && scan_pulse));
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !(reset_en || scan_pulse));
    a_r8_start_ignored_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_pulse && frame_start) |=> (plane == $past(plane)) && !reset_en);
    a_r3_line_holds_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_pulse && $past(scan_pulse)) |-> $stable(line_sel));
endmodule

// File: rtl/sfd_sequencer.sv
module sfd_sequencer #(
    parameter int LINES = 480,
    parameter int COLS  = 4,
    parameter int PIX_W = 8,
    parameter int CNT_W = 16,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SF_W   = $clog2(PIX_W),
    localparam int TOT_W  = CNT_W + PIX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic [CNT_W-1:0]      base_t,
    input  logic [CNT_W-1:0]      reset_len,
    input  logic [CNT_W-1:0]      scan_len,
    input  logic [CNT_W-1:0]      gap_len,
    input  logic [COLS*PIX_W-1:0] rd_pixels,
    output logic                  reset_en,
    output logic                  scan_pulse,
    output logic [LINE_W-1:0]     line_sel,
    output logic [COLS-1:0]       addr_data,
    output logic                  sus_x,
    output logic                  sus_y,
    output logic                  frame_done
);
    logic [SF_W-1:0]  plane;
    logic             sus_start;
    logic             sus_done;
    logic [TOT_W-1:0] sus_total;

    sfd_phase_fsm #(
        .LINES (LINES),
        .PIX_W (PIX_W),
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .base_t      (base_t),
        .reset_len   (reset_len),
        .scan_len    (scan_len),
        .gap_len     (gap_len),
        .sus_done    (sus_done),
        .reset_en    (reset_en),
        .scan_pulse  (scan_pulse),
        .line_sel    (line_sel),
        .plane       (plane),
        .sus_start   (sus_start),
        .sus_total   (sus_total),
        .frame_done  (frame_done)
    );

    sfd_plane_select #(
        .COLS  (COLS),
        .PIX_W (PIX_W)
    ) plane_i (
        .en     (scan_pulse),
        .plane  (plane),
        .pixels (rd_pixels),
        .bits   (addr_data)
    );

    sfd_sustain_pulser #(
        .TOT_W (TOT_W)
    ) pulser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sus_start),
        .total      (sus_total),
        .sus_x      (sus_x),
        .sus_y      (sus_y),
        .burst_done (sus_done)
    );

    a_r4_no_data_outside_scan: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_pulse |-> (addr_data == '0));
    a_r6_no_strobe_while_addressing: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_en || scan_pulse) |-> !(sus_x || sus_y));
endmodule

// File: tb/sfd_sequencer_tb_top.sv
`timescale 1ns/1ps
module sfd_sequencer_tb_top;
    localparam int LINES  = 6;
    localparam int COLS   = 4;
    localparam int CNT_W  = 16;
    localparam int LINE_W = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [CNT_W-1:0] base_t = '0, reset_len = '0, scan_len = '0, gap_len = '0;
    logic [COLS*8-1:0] rd_pixels;
    logic reset_en, scan_pulse, sus_x, sus_y, frame_done;
    logic [LINE_W-1:0] line_sel;
    logic [COLS-1:0] addr_data;

    always #2 clk = ~clk;

    logic [7:0] pix [LINES][COLS];

    always_comb begin
        for (int c = 0; c < COLS; c++)
            rd_pixels[c*8 +: 8] = (int'(line_sel) < LINES) ? pix[line_sel][c] : 8'h00;
    end

    sfd_sequencer #(.LINES(LINES), .COLS(COLS), .PIX_W(8), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .base_t(base_t),
        .reset_len(reset_len), .scan_len(scan_len), .gap_len(gap_len),
        .rd_pixels(rd_pixels), .reset_en(reset_en), .scan_pulse(scan_pulse),
        .line_sel(line_sel), .addr_data(addr_data), .sus_x(sus_x), .sus_y(sus_y),
        .frame_done(frame_done));

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected values taken from the configuration (0 means 1).
    int rl_exp, sl_exp, gl_exp, t_exp;

    // Monitor state
    bit mon_clr = 0;
    int sf_i, exp_line, resets, scans, run_re, run_sp, gap_run, done_cnt;
    int err_reset, err_line, err_scan, err_gap, err_addr, err_both, err_consec, err_alt, err_done_w;
    bit prev_re, prev_sp, prev_sus, prev_done, in_gap, expect_x;
    int pulses [8];
    bit sel [LINES][COLS];
    int lit [LINES][COLS];

    always @(negedge clk) begin
        if (mon_clr) begin
            sf_i = -1; exp_line = 0; resets = 0; scans = 0; run_re = 0; run_sp = 0;
            gap_run = 0; done_cnt = 0; err_reset = 0; err_line = 0; err_scan = 0;
            err_gap = 0; err_addr = 0; err_both = 0; err_consec = 0; err_alt = 0;
            err_done_w = 0; prev_re = 0; prev_sp = 0; prev_sus = 0; prev_done = 0;
            in_gap = 0; expect_x = 1;
            for (int k = 0; k < 8; k++) pulses[k] = 0;
            for (int l = 0; l < LINES; l++)
                for (int c = 0; c < COLS; c++) begin sel[l][c] = 0; lit[l][c] = 0; end
        end else begin
            // erase window
            if (reset_en && !prev_re) begin
                sf_i++; resets++; exp_line = 0; run_re = 1; expect_x = 1; in_gap = 0;
            end else if (reset_en) run_re++;
            if (!reset_en && prev_re && run_re != rl_exp) err_reset++;
            // scan
            if (scan_pulse && !prev_sp) begin
                scans++;
                if (int'(line_sel) != exp_line) err_line++;
                if (in_gap && gap_run != gl_exp) err_gap++;
                in_gap = 0;
                if (int'(line_sel) < LINES && sf_i >= 0 && sf_i < 8)
                    for (int c = 0; c < COLS; c++) begin
                        sel[line_sel][c] = addr_data[c];
                        if (addr_data[c] != pix[line_sel][c][7-sf_i]) err_addr++;
                    end
                exp_line++;
                run_sp = 1;
            end else if (scan_pulse) run_sp++;
            if (!scan_pulse && prev_sp) begin
                if (run_sp != sl_exp) err_scan++;
                in_gap = 1; gap_run = 1;
            end else if (!scan_pulse && in_gap) gap_run++;
            if (!scan_pulse && addr_data != '0) err_addr++;
            // sustain
            if (sus_x && sus_y) err_both++;
            if (sus_x || sus_y) begin
                in_gap = 0;
                if (prev_sus) err_consec++;
                if (sus_x != expect_x) err_alt++;
                expect_x = sus_y;
                if (sf_i >= 0 && sf_i < 8) pulses[sf_i]++;
                for (int l = 0; l < LINES; l++)
                    for (int c = 0; c < COLS; c++) if (sel[l][c]) lit[l][c]++;
            end
            if (frame_done) begin
                done_cnt++;
                if (prev_done) err_done_w++;
            end
            prev_re = reset_en; prev_sp = scan_pulse; prev_sus = sus_x || sus_y;
            prev_done = frame_done;
        end
    end

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1;
        @(posedge clk); mon_clr = 0;
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        chk(!reset_en && !scan_pulse && !sus_x && !sus_y && !frame_done && addr_data == '0,
            req, {reset_en, scan_pulse, sus_x, sus_y, frame_done}, 0);
    endtask

    // R1: reset state and quiet idle
    task automatic test_reset_state();
        check_idle("R1 outputs after reset");
        clear_mon();
        repeat (30) @(negedge clk);
        chk(resets == 0 && scans == 0, "R1 no activity without start", resets + scans, 0);
        check_idle("R1 outputs still idle");
    endtask

    task automatic run_frame(input string name, input int t, input int rl, input int sl,
                             input int gl, input bit mid_start);
        int n;
        @(negedge clk);
        base_t = CNT_W'(t); reset_len = CNT_W'(rl); scan_len = CNT_W'(sl); gap_len = CNT_W'(gl);
        t_exp = t; rl_exp = (rl == 0) ? 1 : rl; sl_exp = (sl == 0) ? 1 : sl; gl_exp = (gl == 0) ? 1 : gl;
        clear_mon();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        if (mid_start) begin
            repeat (40) @(negedge clk);
            frame_start = 1;
            @(negedge clk); frame_start = 0;
        end
        n = 0;
        while (done_cnt == 0 && n < 60000) begin @(negedge clk); n++; end
        chk(done_cnt == 1, {name, " R7 frame_done seen (watchdog)"}, done_cnt, 1);
        repeat (12) @(negedge clk);
        chk(resets == 8, {name, " R2 eight erase windows"}, resets, 8);
        chk(err_reset == 0, {name, " R2 erase window length"}, err_reset, 0);
        chk(scans == 8*LINES && err_line == 0, {name, " R3 line order and count"}, scans, 8*LINES);
        chk(err_scan == 0, {name, " R3 scan pulse length"}, err_scan, 0);
        chk(err_gap == 0, {name, " R3 gap length"}, err_gap, 0);
        chk(err_addr == 0, {name, " R4 bit-plane address data"}, err_addr, 0);
        for (int k = 0; k < 8; k++)
            chk(pulses[k] == (128 >> k) * t, {name, $sformatf(" R5 sustain count sf%0d", k)},
                pulses[k], (128 >> k) * t);
        chk(err_both == 0 && err_consec == 0 && err_alt == 0, {name, " R6 alternation"},
            err_both + err_consec + err_alt, 0);
        chk(done_cnt == 1 && err_done_w == 0, {name, " R7 single done pulse"}, done_cnt, 1);
        begin
            int bad = 0, a = 0, e = 0;
            for (int l = 0; l < LINES; l++)
                for (int c = 0; c < COLS; c++)
                    if (lit[l][c] != int'(pix[l][c]) * t) begin
                        if (bad == 0) begin a = lit[l][c]; e = int'(pix[l][c]) * t; end
                        bad++;
                    end
            chk(bad == 0, {name, " R9 lit pulses per cell"}, a, e);
        end
        check_idle({name, " R7 idle after frame"});
    endtask

    initial begin
        for (int l = 0; l < LINES; l++)
            for (int c = 0; c < COLS; c++) pix[l][c] = 8'((l * 37 + c * 11 + 3) % 256);
        repeat (3) @(negedge clk);
        rst_n = 1;
        test_reset_state();
        run_frame("ramp", 1, 3, 2, 1, 0);
        for (int l = 0; l < LINES; l++) begin
            pix[l][0] = 8'h00; pix[l][1] = 8'hFF;
            pix[l][2] = 8'h80 ^ 8'(l); pix[l][3] = 8'h01 | 8'(l << 1);
        end
        run_frame("edges", 3, 0, 0, 0, 0);
        run_frame("midstart R8", 2, 2, 3, 2, 1);
        run_frame("zeroT R10", 0, 1, 1, 3, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule